// File: doc/BRIEF.md
# Sweep Sensor Readout Sequencer

This block is the host-side controller for a sweep-type linear thermal image sensor that delivers two 4-bit pixels per clock pulse. It generates the sensor's clock, reset and active-low output enable from the system clock, and it collects the pixel nibbles into a byte stream for the host. When the host asks it to start, it holds the sensor reset high, releases it, and then issues four pulses to fill the sensor's output pipeline. It then waits for the next external frame tick and uses that tick to read one full frame, which it throws away because that frame's integration time is not valid.

Every frame tick after that starts one burst of 1124 clock pulses. A frame is 281 columns of 8 pixels, and each pulse carries two pixels. Every pulse produces one output byte with a valid strobe, and the first byte of each frame is marked. Burst starts come only from the fixed-period tick, so the time between frames stays the same even when the bus sits idle between bursts. If a tick arrives while a burst is still running, the tick is dropped and a sticky flag is set.

A nap request parks all interface lines: reset high, clock low, heater enable low and output enable high. The sensor clock period is twice `cfg_half` system cycles. For example, `cfg_half = 25` on a 50 MHz system clock gives 1 MHz at 50% duty.

Top module: `sweep_readout_seq`

## Requirements
- R1: After the synchronous reset the outputs take these values: `sen_rst`=1, `sen_clk`=0, `sen_oe_n`=1, `pix_valid`=0 and `overrun`=0.
- R2: When `start_req` is seen in the idle state:
  - `sen_oe_n` goes low and `sen_rst` stays high for RST_CYC cycles.
  - `sen_rst` then goes low and stays low for `cfg_half` cycles.
  - Exactly 4 priming pulses follow, after which `sen_clk` is parked low.
- R3: Each sensor clock pulse is high for `cfg_half` system cycles and then low for `cfg_half` system cycles (`cfg_half` must be at least 1).
- R4: The first frame tick after priming produces 1124 pulses with no `pix_valid`. This is the discarded frame.
- R5: Each later frame tick produces 1124 pulses and 1124 bytes.
  - Each byte is `{sen_odd, sen_even}`, with the odd nibble in bits 7:4 and the even nibble in bits 3:0.
  - The nibbles are sampled in the last system cycle of the pulse's low phase, so they are the data the sensor presented at that pulse's rising edge.
  - `pix_first` is high together with the first byte of each frame.
- R6: `sen_rst` is never high while `sen_clk` is high, and it stays low for the whole time frames are read.
- R7: A frame tick that arrives while a discard or read burst is running is ignored and sets `overrun`. The flag stays set until the next accepted start.
- R8: Nap behaviour:
  - A `nap_req` seen in the idle state or in either waiting-for-tick state parks the lines: `sen_rst`=1, `sen_clk`=0, `sen_oe_n`=1 and `sen_heat_en`=0.
  - If `nap_req` and `frame_tick` arrive in the same cycle, nap wins and no burst starts.
  - A `nap_req` raised during a burst waits until that burst has finished.
- R9: When `nap_req` drops, the block returns to the idle state with `sen_rst` high and no pulses. A new `start_req` runs the full start sequence again.
- R10: `sen_oe_n` changes only while `sen_clk` is low and was low in the previous cycle.
- R11: `sen_heat_en` follows `heat_req` one cycle later, except during nap, when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_half | input | DIV_W | System cycles per half sensor clock period |
| start_req | input | 1 | One-cycle request to start the sequence |
| nap_req | input | 1 | Level request for nap |
| frame_tick | input | 1 | Fixed-period one-cycle pulse that starts a frame |
| heat_req | input | 1 | Host request for sensor self-heating |
| sen_odd | input | 4 | Odd pixel nibble from the sensor |
| sen_even | input | 4 | Even pixel nibble from the sensor |
| sen_rst | output | 1 | Sensor reset, active high |
| sen_clk | output | 1 | Sensor pixel clock |
| sen_oe_n | output | 1 | Sensor output enable, active low |
| sen_heat_en | output | 1 | Sensor heater enable |
| pix_byte | output | 8 | Captured pixel pair, {odd, even} |
| pix_valid | output | 1 | One-cycle strobe for pix_byte |
| pix_first | output | 1 | Marks the first byte of a frame |
| overrun | output | 1 | Sticky flag for a frame tick that was lost |

## Verification
Two collisions matter here: a frame tick landing in the same cycle as a nap request, and a frame tick landing in the middle of a running burst.

The first collision is provoked by raising `nap_req` and `frame_tick` in the same cycle while the block waits for a tick. The bench then requires the nap line levels and no further rising edges on `sen_clk`.

The second collision is provoked by a tick driven 400 cycles into a read burst. The bench then requires three things:
- `overrun` is set;
- the total pulse count stays exactly that of the frames already scheduled;
- the scoreboard queue drains with nothing extra left over.

A nap raised during a burst is checked by requiring every byte of that frame to arrive before the lines park.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RSTHI,
        S_SETUP,
        S_PRIME,
        S_ARM,
        S_DISC,
        S_WAIT,
        S_READ,
        S_NAP
    } seq_state_t;

    typedef struct packed {
        logic [3:0] odd;
        logic [3:0] even;
    } pix_pair_t;

    function automatic int unsigned frame_pulses(int unsigned cols, int unsigned lines);
        return (cols * lines) / 2;
    endfunction

endpackage

// File: rtl/sen_pulse_gen.sv
module sen_pulse_gen #(
    parameter int DIV_W = 8,
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] half,
    input  logic             go,
    input  logic [CNT_W-1:0] count,
    output logic             sen_clk,
    output logic             sample,
    output logic             done
);

    logic [DIV_W-1:0] hcnt;
    logic [CNT_W-1:0] left;
    logic             run;
    logic             clk_q;
    logic             half_end;

    assign half_end = run && (hcnt == half - DIV_W'(1));
    assign sample   = half_end && !clk_q;
    assign done     = sample && (left == CNT_W'(1));
    assign sen_clk  = clk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= 1'b0;
            clk_q <= 1'b0;
            hcnt  <= '0;
            left  <= '0;
        end else if (go && !run) begin
            run   <= 1'b1;
            clk_q <= 1'b1;
            hcnt  <= '0;
            left  <= count;
        end else if (run) begin
            if (half_end) begin
                hcnt <= '0;
                if (clk_q) begin
                    clk_q <= 1'b0;
                end else begin
                    left <= left - CNT_W'(1);
                    if (left == CNT_W'(1)) begin
                        run <= 1'b0;
                    end else begin
                        clk_q <= 1'b1;
                    end
                end
            end else begin
                hcnt <= hcnt + DIV_W'(1);
            end
        end
    end

    // R3: a new burst is only requested while the engine is idle
    p_go_idle_r3: assert property (@(posedge clk) disable iff (rst)
        go |-> !run);

    // R3: with half >= 2 a rising edge is followed by at least one more high cycle
    p_high_width_r3: assert property (@(posedge clk) disable iff (rst)
        ($rose(sen_clk) && half > DIV_W'(1)) |=> sen_clk);

endmodule

// File: rtl/pix_capture.sv
module pix_capture
    import sweep_pkg::*;
#(
    parameter int FRAME = 1124,
    parameter int IDX_W = 11
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clear,
    input  logic      sample,
    input  pix_pair_t pins,
    output logic [7:0] byte_o,
    output logic      valid,
    output logic      first
);

    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx    <= '0;
            byte_o <= '0;
            valid  <= 1'b0;
            first  <= 1'b0;
        end else begin
            valid <= 1'b0;
            first <= 1'b0;
            if (clear) begin
                idx <= '0;
            end else if (sample) begin
                byte_o <= {pins.odd, pins.even};
                valid  <= 1'b1;
                first  <= (idx == '0);
                idx    <= (idx == IDX_W'(FRAME - 1)) ? '0 : idx + IDX_W'(1);
            end
        end
    end

    // R5: one byte per pulse, so two strobes are never back to back
    p_valid_gap_r5: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

endmodule

// File: rtl/sweep_readout_seq.sv
module sweep_readout_seq
    import sweep_pkg::*;
#(
    parameter int COLUMNS      = 281,
    parameter int LINES        = 8,
    parameter int PRIME_PULSES = 4,
    parameter int RST_CYC      = 8,
    parameter int DIV_W        = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] cfg_half,
    input  logic             start_req,
    input  logic             nap_req,
    input  logic             frame_tick,
    input  logic             heat_req,
    input  logic [3:0]       sen_odd,
    input  logic [3:0]       sen_even,
    output logic             sen_rst,
    output logic             sen_clk,
    output logic             sen_oe_n,
    output logic             sen_heat_en,
    output logic [7:0]       pix_byte,
    output logic             pix_valid,
    output logic             pix_first,
    output logic             overrun
);

    localparam int FRAME = int'(frame_pulses(COLUMNS, LINES));
    localparam int CNT_W = $clog2(FRAME + 1);
    localparam int IDX_W = $clog2(FRAME);
    localparam int RW    = $clog2(RST_CYC + 1);
    localparam int TW    = (DIV_W > RW) ? DIV_W : RW;

    seq_state_t       st, st_n;
    logic [TW-1:0]    tcnt;
    logic             go, clr, start_ok;
    logic [CNT_W-1:0] go_cnt;
    logic             sample, done;
    logic             rst_q, oe_n_q, heat_q, ovr_q;
    pix_pair_t        pins;

    always_comb begin
        st_n     = st;
        go       = 1'b0;
        go_cnt   = CNT_W'(FRAME);
        clr      = 1'b0;
        start_ok = 1'b0;
        case (st)
            S_IDLE:  if (nap_req) st_n = S_NAP;
                     else if (start_req) begin
                         st_n     = S_RSTHI;
                         start_ok = 1'b1;
                     end
            S_RSTHI: if (tcnt == TW'(RST_CYC - 1)) st_n = S_SETUP;
            S_SETUP: if (tcnt == TW'(cfg_half) - TW'(1)) begin
                         st_n   = S_PRIME;
                         go     = 1'b1;
                         go_cnt = CNT_W'(PRIME_PULSES);
                     end
            S_PRIME: if (done) st_n = S_ARM;
            S_ARM:   if (nap_req) st_n = S_NAP;
                     else if (frame_tick) begin
                         st_n = S_DISC;
                         go   = 1'b1;
                     end
            S_DISC:  if (done) st_n = S_WAIT;
            S_WAIT:  if (nap_req) st_n = S_NAP;
                     else if (frame_tick) begin
                         st_n = S_READ;
                         go   = 1'b1;
                         clr  = 1'b1;
                     end
            S_READ:  if (done) st_n = S_WAIT;
            S_NAP:   if (!nap_req) st_n = S_IDLE;
            default: st_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            tcnt   <= '0;
            rst_q  <= 1'b1;
            oe_n_q <= 1'b1;
            heat_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            st     <= st_n;
            tcnt   <= (st_n != st) ? '0 : tcnt + TW'(1);
            rst_q  <= (st_n == S_IDLE) || (st_n == S_RSTHI) || (st_n == S_NAP);
            oe_n_q <= (st_n == S_IDLE) || (st_n == S_NAP);
            heat_q <= heat_req && (st_n != S_NAP);
            if (start_ok) ovr_q <= 1'b0;
            else if (frame_tick && (st == S_DISC || st == S_READ)) ovr_q <= 1'b1;
        end
    end

    sen_pulse_gen #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_pulse (
        .clk     (clk),
        .rst     (rst),
        .half    (cfg_half),
        .go      (go),
        .count   (go_cnt),
        .sen_clk (sen_clk),
        .sample  (sample),
        .done    (done)
    );

    assign pins.odd  = sen_odd;
    assign pins.even = sen_even;

    pix_capture #(.FRAME(FRAME), .IDX_W(IDX_W)) u_cap (
        .clk    (clk),
        .rst    (rst),
        .clear  (clr),
        .sample (sample && st == S_READ),
        .pins   (pins),
        .byte_o (pix_byte),
        .valid  (pix_valid),
        .first  (pix_first)
    );

    assign sen_rst     = rst_q;
    assign sen_oe_n    = oe_n_q;
    assign sen_heat_en = heat_q;
    assign overrun     = ovr_q;

    // R6: the sensor never sees a clock pulse while it is held in reset
    p_rst_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        sen_clk |-> !sen_rst);

    // R10: output enable only moves while the clock is parked low
    p_oe_parked_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(sen_oe_n) |-> (!sen_clk && !$past(sen_clk)));

    // R8: once nap is settled every interface line is parked
    p_nap_lines_r8: assert property (@(posedge clk) disable iff (rst)
        (st == S_NAP && $past(st == S_NAP)) |-> (sen_rst && !sen_clk && sen_oe_n && !sen_heat_en));

    // R7: the overrun flag is only cleared by an accepted start
    p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (overrun && !start_ok) |=> overrun);

    // R4: the discarded frame produces no output bytes
    p_discard_silent_r4: assert property (@(posedge clk) disable iff (rst)
        (st == S_DISC) |-> !pix_valid);

endmodule

// File: tb/sweep_readout_seq_test.sv
module sweep_readout_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;
    localparam int FRAME      = 1124;
    localparam int PRIMED     = 4 + FRAME;
    localparam int TICK_GAP   = 5000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cfg_half = 8'(HALF);
    logic       start_req = 1'b0;
    logic       nap_req = 1'b0;
    logic       frame_tick = 1'b0;
    logic       heat_req = 1'b0;
    logic [3:0] sen_odd, sen_even;
    logic       sen_rst, sen_clk, sen_oe_n, sen_heat_en;
    logic [7:0] pix_byte;
    logic       pix_valid, pix_first, overrun;

    int checks = 0;
    int errors = 0;
    int rises = 0;
    int rst_bad = 0;
    int oe_bad = 0;
    int popped = 0;
    int cyc_no = 0;
    int k = 0;
    logic prev_oe = 1'b1;
    logic prev_clk = 1'b0;
    logic [8:0] q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    sweep_readout_seq uut (
        .clk(clk), .rst(rst), .cfg_half(cfg_half), .start_req(start_req),
        .nap_req(nap_req), .frame_tick(frame_tick), .heat_req(heat_req),
        .sen_odd(sen_odd), .sen_even(sen_even), .sen_rst(sen_rst),
        .sen_clk(sen_clk), .sen_oe_n(sen_oe_n), .sen_heat_en(sen_heat_en),
        .pix_byte(pix_byte), .pix_valid(pix_valid), .pix_first(pix_first),
        .overrun(overrun)
    );

    function automatic logic [7:0] pat(int kk);
        return 8'((kk * 29 + 11) % 256);
    endfunction

    // sensor model: new pixel pair on every rising clock edge, counter cleared by reset
    always @(posedge sen_clk or posedge sen_rst) begin
        if (sen_rst) k <= 0;
        else         k <= k + 1;
    end
    assign {sen_odd, sen_even} = pat(k);

    always @(posedge clk) cyc_no <= cyc_no + 1;

    always @(posedge sen_clk) begin
        rises <= rises + 1;
        if (sen_rst) rst_bad <= rst_bad + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: R10 output-enable guard, and the scoreboard for R5
    always @(negedge clk) begin
        if (!rst && sen_oe_n !== prev_oe && (sen_clk || prev_clk)) oe_bad++;
        prev_oe  = sen_oe_n;
        prev_clk = sen_clk;
        if (!rst && pix_valid) begin
            popped++;
            if (q.size() == 0) begin
                chk(1'b0, "R5 unexpected byte", int'(pix_byte), -1);
            end else begin
                logic [8:0] it;
                it = q.pop_front();
                chk(pix_byte == it[7:0], "R5 byte", int'(pix_byte), int'(it[7:0]));
                chk(pix_first == it[8], "R5 first flag", int'(pix_first), int'(it[8]));
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_frame(input int base);
        for (int j = 1; j <= FRAME; j++) q.push_back({(j == 1), pat(base + j)});
    endtask

    task automatic wait_rises(input int target);
        while (rises < target) @(negedge clk);
        cyc(4 * HALF + 4);
    endtask

    task automatic pulse_start();
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
    endtask

    task automatic tick_at(input int t);
        while (cyc_no < t) @(negedge clk);
        frame_tick = 1'b1;
        @(negedge clk) frame_tick = 1'b0;
    endtask

    bit finished = 1'b0;

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cyc_no, 0);
            summary();
        end
    end

    initial begin
        int t0;
        int r0;
        cyc(5);
        rst = 1'b0;
        cyc(2);
        chk(sen_rst == 1'b1, "R1 sen_rst", int'(sen_rst), 1);
        chk(sen_clk == 1'b0, "R1 sen_clk", int'(sen_clk), 0);
        chk(sen_oe_n == 1'b1, "R1 sen_oe_n", int'(sen_oe_n), 1);
        chk(pix_valid == 1'b0, "R1 pix_valid", int'(pix_valid), 0);
        chk(overrun == 1'b0, "R1 overrun", int'(overrun), 0);

        heat_req = 1'b1;
        cyc(2);
        chk(sen_heat_en == 1'b1, "R11 heater follows", int'(sen_heat_en), 1);

        // R2 start sequence
        pulse_start();
        cyc(3);
        chk(sen_rst == 1'b1, "R2 reset held", int'(sen_rst), 1);
        chk(sen_oe_n == 1'b0, "R2 oe low", int'(sen_oe_n), 0);
        wait_rises(4);
        cyc(10);
        chk(rises == 4, "R2 prime pulses", rises, 4);
        chk(sen_rst == 1'b0, "R2 reset released", int'(sen_rst), 0);
        chk(sen_clk == 1'b0, "R2 clock parked", int'(sen_clk), 0);

        // R3 pulse shape, measured on the discard burst
        t0 = cyc_no + 5;
        tick_at(t0);
        begin
            int hi = 0;
            int lo = 0;
            while (sen_clk !== 1'b1) @(negedge clk);
            while (sen_clk === 1'b1) begin hi++; @(negedge clk); end
            while (sen_clk === 1'b0) begin lo++; @(negedge clk); end
            chk(hi == HALF, "R3 high width", hi, HALF);
            chk(lo == HALF, "R3 low width", lo, HALF);
        end
        wait_rises(PRIMED);
        chk(popped == 0, "R4 discard silent", popped, 0);

        // R5 frames, R7 overrun on frame 2, R8 deferred nap on frame 3
        for (int f = 0; f < 3; f++) begin
            chk(rises == PRIMED + FRAME * f, "R7 no extra burst", rises, PRIMED + FRAME * f);
            push_frame(PRIMED + FRAME * f);
            tick_at(t0 + TICK_GAP * (f + 1));
            if (f == 1) begin
                cyc(400);
                frame_tick = 1'b1;
                @(negedge clk) frame_tick = 1'b0;
                cyc(2);
                chk(overrun == 1'b1, "R7 overrun set", int'(overrun), 1);
            end
            if (f == 2) begin
                cyc(400);
                nap_req = 1'b1;
            end
            wait_rises(PRIMED + FRAME * (f + 1));
            chk(q.size() == 0, "R5 frame complete", q.size(), 0);
        end
        cyc(5);
        chk(rises == PRIMED + 3 * FRAME, "R8 deferred nap kept burst", rises, PRIMED + 3 * FRAME);
        chk(sen_rst == 1'b1, "R8 nap reset", int'(sen_rst), 1);
        chk(sen_clk == 1'b0, "R8 nap clock", int'(sen_clk), 0);
        chk(sen_oe_n == 1'b1, "R8 nap oe", int'(sen_oe_n), 1);
        chk(sen_heat_en == 1'b0, "R8 nap heater", int'(sen_heat_en), 0);

        // R9 leave nap to idle
        nap_req = 1'b0;
        r0 = rises;
        cyc(50);
        chk(rises == r0, "R9 idle no pulses", rises, r0);
        chk(sen_rst == 1'b1, "R9 idle reset", int'(sen_rst), 1);
        chk(sen_oe_n == 1'b1, "R9 idle oe", int'(sen_oe_n), 1);
        chk(sen_heat_en == 1'b1, "R11 heater after nap", int'(sen_heat_en), 1);
        chk(overrun == 1'b1, "R7 overrun sticky", int'(overrun), 1);

        // restart: overrun cleared, full sequence again
        pulse_start();
        cyc(3);
        chk(overrun == 1'b0, "R7 overrun cleared", int'(overrun), 0);
        wait_rises(r0 + 4);
        chk(rises == r0 + 4, "R9 restart primes", rises, r0 + 4);
        tick_at(cyc_no + 10);
        wait_rises(r0 + PRIMED);
        chk(popped == 3 * FRAME, "R4 second discard silent", popped, 3 * FRAME);

        // R8 nap and tick in the same cycle: nap wins
        @(negedge clk);
        nap_req = 1'b1;
        frame_tick = 1'b1;
        @(negedge clk) frame_tick = 1'b0;
        cyc(200);
        chk(rises == r0 + PRIMED, "R8 nap beats tick", rises, r0 + PRIMED);
        chk(sen_rst == 1'b1 && sen_oe_n == 1'b1 && sen_heat_en == 1'b0, "R8 nap lines",
            int'({sen_rst, sen_oe_n, sen_heat_en}), 6);
        chk(popped == 3 * FRAME, "R8 no bytes in nap", popped, 3 * FRAME);

        chk(oe_bad == 0, "R10 oe guard", oe_bad, 0);
        chk(rst_bad == 0, "R6 reset low while clocking", rst_bad, 0);

        finished = 1'b1;
        summary();
    end

endmodule